// File: doc/BRIEF.md
# DRAM Command Decoder with Per-Bank Row Tracking

This block sits on the command side of a DDR3-style memory device model or a controller's shadow of it. Each rising clock edge it samples chip select, clock enable, the three active-low strobe lines (row strobe, column strobe, write enable), the bank address and the address bus. It turns them into exactly one registered command strobe for the following cycle, together with the bank index, the address field that matters for that command, and the context-dependent meaning of address bit 10.

The block also keeps a small table with one entry per bank. Each entry records whether the bank has a row open and, if so, which row. Activates open a bank. Single-bank or all-bank precharges close banks. Reads and writes that request auto-precharge close their bank. Mode-register loads are routed by the low two bank-address bits to one of four register indices, and the address bus carries the op-code. A command that reads or writes a closed bank, or that activates a bank already open, raises a one-cycle protocol-error flag and leaves the table unchanged.

Top module: `dram_cmd_tracker`

## Requirements
- R1: A command sampled at a rising edge appears on exactly one strobe output during the following cycle. The strobe is chosen by {row strobe, column strobe, write enable} = 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 110 calibration. 111 gives no strobe.
- R2: When chip select is sampled high, the cycle is a no-operation. No strobe fires and the bank table does not change.
- R3: When clock enable is sampled low, the cycle is a no-operation. Commands are accepted again on the first edge where it is sampled high.
- R4: An activate to a closed bank reports the bank and the full 14-bit row on the command outputs. From the next cycle on, that bank shows open with that row.
- R5: A read or write reports address bits 9:0 as the column, with the upper output bits zero. It reports address bit 10 on the auto-precharge flag.
- R6: A read or write with address bit 10 high, accepted on an open bank, leaves that bank closed. Without bit 10 the bank stays open with its row unchanged.
- R7: A precharge with address bit 10 low closes only the addressed bank. With bit 10 high it closes every bank and raises the precharge-all flag.
- R8: A mode load reports bank-address bits 1:0 as the mode-register index and the full address bus as the op-code.
- R9: A read or write to a closed bank, or an activate to an open bank, raises the protocol-error flag for exactly one cycle. The bank table is left unchanged.
- R10: Asynchronous reset clears all strobes, flags and bank entries. Its release is synchronised, and commands are accepted from the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable, high accepts commands |
| ba | input | 3 | Bank address |
| addr | input | 14 | Address bus |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Read strobe |
| cmd_wr | output | 1 | Write strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_ref | output | 1 | Refresh strobe |
| cmd_mrs | output | 1 | Mode-register load strobe |
| cmd_zq | output | 1 | Calibration strobe |
| cmd_bank | output | 3 | Bank of the current command |
| cmd_addr | output | 14 | Row, column or op-code of the current command |
| auto_pre | output | 1 | Auto-precharge requested by read/write |
| pre_all | output | 1 | Precharge targets all banks |
| mr_sel | output | 2 | Mode register index of a mode load |
| bank_open | output | 8 | Per-bank open status |
| open_rows | output | 112 | Open row per bank, bank b in bits 14b+13:14b |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
The bound checker watches every cycle for properties that hold regardless of the traffic. It checks that at most one strobe fires and that a deselected or clock-disabled cycle yields no strobe. It checks that an accepted activate leaves its bank open and that an auto-precharge or precharge-all leaves the affected banks closed. It also checks that the error flag only accompanies activate, read or write. Only the directed scenarios can show the actual values: the row stored and kept across a rejected second activate, the column and op-code fields, a single-bank precharge sparing its neighbours, the one-cycle width of the error pulse, and acceptance resuming once clock enable returns.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // Encoding of {ras_n, cas_n, we_n} with chip select low
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_ZQ  = 3'b110,
    CMD_NOP = 3'b111
  } dram_cmd_e;

  localparam int unsigned MR_SEL_W = 2;
endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  input  logic      cke,
  output dram_cmd_e cmd
);
  always_comb begin
    if (!cke || cs_n) cmd = CMD_NOP;
    else              cmd = dram_cmd_e'({ras_n, cas_n, we_n});
  end
endmodule

// File: rtl/dct_bank_table.sv
module dct_bank_table
  import dct_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dram_cmd_e                  cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       err
);
  logic target_open;
  logic is_col;

  assign target_open = bank_open[ba];
  assign is_col      = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    err = (is_col && !target_open) || ((cmd == CMD_ACT) && target_open);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             sel;
    logic             open_q;
    logic             open_d;
    logic             row_en;
    logic [ROW_W-1:0] row_q;

    assign sel = (ba == BA_W'(g));

    always_comb begin
      open_d = open_q;
      row_en = 1'b0;
      unique case (cmd)
        CMD_ACT: if (sel && !open_q) begin
          open_d = 1'b1;
          row_en = 1'b1;
        end
        CMD_PRE: if (sel || addr[AP_BIT]) open_d = 1'b0;
        CMD_RD, CMD_WR: if (sel && open_q && addr[AP_BIT]) open_d = 1'b0;
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= open_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q <= addr;
    end

    assign bank_open[g]                  = open_q;
    assign open_rows[g*ROW_W +: ROW_W]   = row_q;
  end
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       cke,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic                       cmd_act,
  output logic                       cmd_rd,
  output logic                       cmd_wr,
  output logic                       cmd_pre,
  output logic                       cmd_ref,
  output logic                       cmd_mrs,
  output logic                       cmd_zq,
  output logic [BA_W-1:0]            cmd_bank,
  output logic [ROW_W-1:0]           cmd_addr,
  output logic                       auto_pre,
  output logic                       pre_all,
  output logic [MR_SEL_W-1:0]        mr_sel,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       proto_err
);
  localparam int unsigned NSTROBE = 7;
  localparam int unsigned PAD_W   = ROW_W - COL_W;

  logic      rst_core_n;
  dram_cmd_e cmd;
  logic      tbl_err;

  dct_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  dct_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
  );

  dct_bank_table #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
  ) u_tbl (
    .clk(clk), .rst_n(rst_core_n), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_rows(open_rows), .err(tbl_err)
  );

  // next-state of the registered command outputs
  logic [NSTROBE-1:0]  strobe_d, strobe_q;
  logic [BA_W-1:0]     bank_d, bank_q;
  logic [ROW_W-1:0]    addr_d, addr_q;
  logic                ap_d, ap_q;
  logic                pall_d, pall_q;
  logic [MR_SEL_W-1:0] mr_d, mr_q;
  logic                err_d, err_q;

  always_comb begin
    strobe_d = '0;
    bank_d   = '0;
    addr_d   = '0;
    ap_d     = 1'b0;
    pall_d   = 1'b0;
    mr_d     = '0;
    err_d    = tbl_err;
    unique case (cmd)
      CMD_ACT: begin
        strobe_d[6] = 1'b1;
        bank_d      = ba;
        addr_d      = addr;
      end
      CMD_RD, CMD_WR: begin
        strobe_d[5] = (cmd == CMD_RD);
        strobe_d[4] = (cmd == CMD_WR);
        bank_d      = ba;
        addr_d      = {{PAD_W{1'b0}}, addr[COL_W-1:0]};
        ap_d        = addr[AP_BIT];
      end
      CMD_PRE: begin
        strobe_d[3] = 1'b1;
        bank_d      = ba;
        pall_d      = addr[AP_BIT];
      end
      CMD_REF: strobe_d[2] = 1'b1;
      CMD_MRS: begin
        strobe_d[1] = 1'b1;
        addr_d      = addr;
        mr_d        = ba[MR_SEL_W-1:0];
      end
      CMD_ZQ:  strobe_d[0] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      strobe_q <= '0;
      bank_q   <= '0;
      addr_q   <= '0;
      ap_q     <= 1'b0;
      pall_q   <= 1'b0;
      mr_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      bank_q   <= bank_d;
      addr_q   <= addr_d;
      ap_q     <= ap_d;
      pall_q   <= pall_d;
      mr_q     <= mr_d;
      err_q    <= err_d;
    end
  end

  assign {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_zq} = strobe_q;
  assign cmd_bank  = bank_q;
  assign cmd_addr  = addr_q;
  assign auto_pre  = ap_q;
  assign pre_all   = pall_q;
  assign mr_sel    = mr_q;
  assign proto_err = err_q;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BA_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 cke,
  input logic                 cmd_act,
  input logic                 cmd_rd,
  input logic                 cmd_wr,
  input logic                 cmd_pre,
  input logic                 cmd_ref,
  input logic                 cmd_mrs,
  input logic                 cmd_zq,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 auto_pre,
  input logic                 pre_all,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 proto_err
);
  logic [6:0] strobes;
  assign strobes = {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_zq};

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  a_r2_deselect_nop: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (strobes == '0));

  a_r3_cke_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (strobes == '0));

  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act && !proto_err) |-> bank_open[cmd_bank]);

  a_r6_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_rd || cmd_wr) && auto_pre && !proto_err) |-> !bank_open[cmd_bank]);

  a_r7_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && pre_all) |-> (bank_open == '0));

  a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (cmd_act || cmd_rd || cmd_wr));
endmodule

bind dram_cmd_tracker dct_checker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cke(cke),
  .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
  .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_zq(cmd_zq), .cmd_bank(cmd_bank),
  .auto_pre(auto_pre), .pre_all(pre_all), .bank_open(bank_open), .proto_err(proto_err)
);

// File: tb/tb_dram_cmd_tracker.sv
module tb_dram_cmd_tracker;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [2:0] E_MRS = 3'b000, E_REF = 3'b001, E_PRE = 3'b010, E_ACT = 3'b011,
                         E_WR  = 3'b100, E_RD  = 3'b101, E_ZQ  = 3'b110;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, cke;
  logic [2:0]  ba;
  logic [13:0] addr;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_zq;
  logic [2:0]  cmd_bank;
  logic [13:0] cmd_addr;
  logic auto_pre, pre_all, proto_err;
  logic [1:0]  mr_sel;
  logic [7:0]  bank_open;
  logic [111:0] open_rows;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_zq(cmd_zq),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .auto_pre(auto_pre), .pre_all(pre_all),
    .mr_sel(mr_sel), .bank_open(bank_open), .open_rows(open_rows), .proto_err(proto_err)
  );

  function automatic logic [6:0] strobes();
    return {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_zq};
  endfunction

  function automatic logic [13:0] row_of(int b);
    return open_rows[b*14 +: 14];
  endfunction

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // drive one command before the next rising edge, return just after it
  task automatic issue(logic c_cs, logic c_cke, logic [2:0] enc, logic [2:0] b, logic [13:0] a);
    @(negedge clk);
    cs_n = c_cs; cke = c_cke; {ras_n, cas_n, we_n} = enc; ba = b; addr = a;
    @(posedge clk);
    #1;
    cs_n = 1'b1; cke = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
  endtask

  task automatic nop();
    issue(1'b1, 1'b1, 3'b111, 3'd0, 14'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cs_n = 1'b1; cke = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 strobes in reset", 32'(strobes()), 0);
    chk("R10 banks in reset", 32'(bank_open), 0);
    chk("R10 error in reset", 32'(proto_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    nop(); nop(); nop();
    chk("R10 strobes after release", 32'(strobes()), 0);
  endtask

  task automatic t_activate();
    issue(1'b0, 1'b1, E_ACT, 3'd3, 14'h2ABC);
    chk("R1 activate strobe", 32'(strobes()), 32'h40);
    chk("R4 activate bank", 32'(cmd_bank), 3);
    chk("R4 activate row", 32'(cmd_addr), 32'h2ABC);
    chk("R4 bank open", 32'(bank_open), 32'h08);
    chk("R4 open row", 32'(row_of(3)), 32'h2ABC);
  endtask

  task automatic t_read_write();
    issue(1'b0, 1'b1, E_RD, 3'd3, 14'h3955);  // A10 low, col 0x155
    chk("R1 read strobe", 32'(strobes()), 32'h20);
    chk("R5 read column", 32'(cmd_addr), 32'h155);
    chk("R5 read no autopre", 32'(auto_pre), 0);
    chk("R6 bank stays open", 32'(bank_open), 32'h08);
    chk("R6 row kept", 32'(row_of(3)), 32'h2ABC);
    issue(1'b0, 1'b1, E_WR, 3'd3, 14'h04AA);  // A10 high, col 0x0AA
    chk("R1 write strobe", 32'(strobes()), 32'h10);
    chk("R5 write column", 32'(cmd_addr), 32'h0AA);
    chk("R5 write autopre", 32'(auto_pre), 1);
    chk("R6 autopre closes", 32'(bank_open), 0);
    chk("R9 no error on valid write", 32'(proto_err), 0);
  endtask

  task automatic t_errors();
    issue(1'b0, 1'b1, E_RD, 3'd3, 14'h0400);
    chk("R9 read closed bank error", 32'(proto_err), 1);
    chk("R9 table unchanged", 32'(bank_open), 0);
    nop();
    chk("R9 error one cycle", 32'(proto_err), 0);
    issue(1'b0, 1'b1, E_ACT, 3'd5, 14'h1111);
    chk("R9 first act ok", 32'(proto_err), 0);
    issue(1'b0, 1'b1, E_ACT, 3'd5, 14'h2222);
    chk("R9 double act error", 32'(proto_err), 1);
    chk("R9 row not replaced", 32'(row_of(5)), 32'h1111);
    issue(1'b0, 1'b1, E_WR, 3'd0, 14'h0000);
    chk("R9 write closed bank error", 32'(proto_err), 1);
  endtask

  task automatic t_precharge();
    issue(1'b0, 1'b1, E_ACT, 3'd1, 14'h0101);
    issue(1'b0, 1'b1, E_ACT, 3'd2, 14'h0202);
    chk("R4 three banks open", 32'(bank_open), 32'h26);
    issue(1'b0, 1'b1, E_PRE, 3'd1, 14'h0000);
    chk("R1 precharge strobe", 32'(strobes()), 32'h08);
    chk("R7 single closes only bank1", 32'(bank_open), 32'h24);
    chk("R7 single not all", 32'(pre_all), 0);
    issue(1'b0, 1'b1, E_PRE, 3'd0, 14'h0400);
    chk("R7 all flag", 32'(pre_all), 1);
    chk("R7 all closed", 32'(bank_open), 0);
  endtask

  task automatic t_deselect();
    issue(1'b1, 1'b1, E_ACT, 3'd4, 14'h0444);
    chk("R2 no strobe when deselected", 32'(strobes()), 0);
    chk("R2 no bank change", 32'(bank_open), 0);
  endtask

  task automatic t_cke();
    issue(1'b0, 1'b0, E_ACT, 3'd6, 14'h0666);
    chk("R3 no strobe with cke low", 32'(strobes()), 0);
    chk("R3 no bank change", 32'(bank_open), 0);
    issue(1'b0, 1'b1, E_ACT, 3'd6, 14'h0666);
    chk("R3 resumes", 32'(bank_open), 32'h40);
  endtask

  task automatic t_misc();
    issue(1'b0, 1'b1, E_MRS, 3'd2, 14'h1234);
    chk("R1 mode load strobe", 32'(strobes()), 32'h02);
    chk("R8 register index", 32'(mr_sel), 2);
    chk("R8 op-code", 32'(cmd_addr), 32'h1234);
    issue(1'b0, 1'b1, E_REF, 3'd0, 14'h0000);
    chk("R1 refresh strobe", 32'(strobes()), 32'h04);
    issue(1'b0, 1'b1, E_ZQ, 3'd0, 14'h0400);
    chk("R1 calibration strobe", 32'(strobes()), 32'h01);
    issue(1'b0, 1'b1, 3'b111, 3'd0, 14'h0000);
    chk("R1 nop encoding no strobe", 32'(strobes()), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_activate();
    t_read_write();
    t_errors();
    t_precharge();
    t_deselect();
    t_cke();
    t_misc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule